// File: doc/BRIEF.md
# Indirect Channel Parameter Window

This block keeps a table of 16-bit parameters, one entry per channel, and lets a host reach any entry through two registers: a select word and a data word. The host never addresses the table directly. Writing the select word names a channel and says whether to fetch or to store. The block then carries out the move over a fixed number of cycles and shows a busy flag in the select word while it works.

To store a value, the host first places it in the data word, then writes the select word with the direction bit clear, then polls until busy drops. To fetch a value, the host writes the select word with the direction bit set, polls until busy drops, and then reads the data word. The fixed latencies stand in for the time an internal arbiter would need to reach the table.

Top module: `chan_param_window`

## Requirements
- R1: After reset, a host read of the select word (address 0) and a host read of the data word (address 1) both return 0000h.
- R2: The select word reads back as follows. Bits 7:0 hold the channel code, where 00h is the first channel and FFh the last. Bit 14 holds the direction, 1 for fetch and 0 for store. Bit 15 is busy. Bits 13:8 always read 0.
- R3: A host write to the select word while busy is low launches an access at once. Bit 14 of the written value picks a fetch (1) or a store (0), and bits 7:0 pick the channel.
- R4: For a fetch, busy reads 1 for exactly 3 cycles after the launching write. When busy clears, the data word holds the entry of the selected channel.
- R5: For a store, busy reads 1 for exactly 2 cycles after the launching write. The data word value is then held in the entry of the selected channel.
- R6: A host write to the select word while busy is high is ignored: the channel, the direction and the running access are all unchanged.
- R7: A host write to the data word while busy is high is ignored.
- R8: Bit 15 of a value written to the select word has no effect. Busy follows only the access timing.
- R9: A host read strobe returns the addressed register on hst_rdata after the next rising edge. Address 0 selects the select word and address 1 the data word. The data word can be written at any time busy is low.
- R10: Every channel from 00h to FFh has its own entry. A store to one channel leaves the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_stb | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 1 | 0 = select word, 1 = data word |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Registered host read data |

## Verification
The assertions assume that each host access is a single-cycle strobe with a stable address and write enable. They also assume that a fetch is only checked against entries that have already been stored, because the table itself has no reset. The directed stimulus keeps to these limits. It issues one access per cycle and polls busy only with reads. It reads back only channels that it stored earlier in the same run. While an access is running, it writes the registers on purpose, to show that those writes are ignored.

// File: rtl/chan_param_window.sv
module chan_param_window #(
  parameter int CH_W   = 8,
  parameter int RD_LAT = 3,
  parameter int WR_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_stb,
  input  logic        hst_we,
  input  logic        hst_addr,
  input  logic [15:0] hst_wdata,
  output logic [15:0] hst_rdata
);
  localparam int DEPTH = 1 << CH_W;
  localparam int MAXL  = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW    = $clog2(MAXL + 1);

  logic [15:0]     ram [DEPTH];
  logic [CH_W-1:0] ch_q;
  logic            rw_q;
  logic            busy_q;
  logic [CW-1:0]   cnt_q;
  logic [15:0]     data_q;

  wire        sel_wr   = hst_stb & hst_we & ~hst_addr & ~busy_q;
  wire        dat_wr   = hst_stb & hst_we &  hst_addr & ~busy_q;
  wire        done     = busy_q & (cnt_q == '0);
  wire [15:0] sel_word = {busy_q, rw_q, {(14-CH_W){1'b0}}, ch_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q   <= '0;
      rw_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sel_wr) begin
      ch_q   <= hst_wdata[CH_W-1:0];
      rw_q   <= hst_wdata[14];
      busy_q <= 1'b1;
      cnt_q  <= hst_wdata[14] ? CW'(RD_LAT - 1) : CW'(WR_LAT - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               data_q <= '0;
    else if (dat_wr)          data_q <= hst_wdata;
    else if (done && rw_q)    data_q <= ram[ch_q];
  end

  always_ff @(posedge clk) begin
    if (done && !rw_q) ram[ch_q] <= data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  hst_rdata <= '0;
    else if (hst_stb && !hst_we) hst_rdata <= hst_addr ? data_q : sel_word;
  end
endmodule

// File: rtl/chan_param_window_chk.sv
module chan_param_window_chk #(
  parameter int CH_W   = 8,
  parameter int RD_LAT = 3,
  parameter int WR_LAT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hst_stb,
  input logic            hst_we,
  input logic            hst_addr,
  input logic [15:0]     hst_wdata,
  input logic [15:0]     hst_rdata,
  input logic            busy_q,
  input logic            rw_q,
  input logic [CH_W-1:0] ch_q,
  input logic [15:0]     data_q
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (busy_q) run <= run + 1'b1;
    else             run <= '0;
  end

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && hst_we && !hst_addr && !busy_q) |=>
      (busy_q && rw_q == $past(hst_wdata[14]) && ch_q == $past(hst_wdata[CH_W-1:0])));

  p_rd_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && rw_q) |-> (run == 8'(RD_LAT)));

  p_wr_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !rw_q) |-> (run == 8'(WR_LAT)));

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(ch_q) && $stable(rw_q)));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rw_q && hst_stb && hst_we && hst_addr) |=> $stable(data_q));

  p_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && !hst_we && hst_addr) |=> (hst_rdata == $past(data_q)));
endmodule

bind chan_param_window chan_param_window_chk #(
  .CH_W(CH_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_stb(hst_stb), .hst_we(hst_we),
  .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
  .busy_q(busy_q), .rw_q(rw_q), .ch_q(ch_q), .data_q(data_q)
);

// File: tb/test_chan_param_window.sv
`timescale 1ns/1ps
module test_chan_param_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_stb = 1'b0;
  logic        hst_we = 1'b0;
  logic        hst_addr = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  chan_param_window i_chan_param_window (
    .clk(clk), .rst_n(rst_n), .hst_stb(hst_stb), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic a, logic [15:0] d);
    hst_stb = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); @(negedge clk);
    hst_stb = 1'b0; hst_we = 1'b0;
  endtask

  task automatic hrd(logic a, output logic [15:0] d);
    hst_stb = 1'b1; hst_we = 1'b0; hst_addr = a;
    @(posedge clk); @(negedge clk);
    hst_stb = 1'b0;
    d = hst_rdata;
  endtask

  task automatic poll(output int n);
    logic [15:0] v;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      hrd(1'b0, v);
      if (v[15]) n++;
      else break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    hrd(1'b0, v); chk("R1 select after reset", v, 16'h0000);
    hrd(1'b1, v); chk("R1 data after reset", v, 16'h0000);
  endtask

  task automatic t_roundtrip(logic [7:0] ch, logic [15:0] val);
    logic [15:0] v;
    int n;
    hwr(1'b1, val);
    hrd(1'b1, v); chk("R9 data readback", v, val);
    hwr(1'b0, {8'h00, ch});
    poll(n); chk("R5 store busy cycles", 16'(n), 16'd2);
    hwr(1'b1, 16'h0000);
    hwr(1'b0, {8'h40, ch});
    poll(n); chk("R4 fetch busy cycles", 16'(n), 16'd3);
    hrd(1'b1, v); chk("R4 fetched value", v, val);
    hrd(1'b0, v); chk("R2 select layout after fetch", v, {8'h40, ch});
  endtask

  task automatic t_channels();
    logic [15:0] v;
    int n;
    hwr(1'b0, 16'h4000);
    poll(n);
    hrd(1'b1, v); chk("R10 channel 00h unchanged", v, 16'hA5A5);
    hwr(1'b0, 16'h40FF);
    poll(n);
    hrd(1'b1, v); chk("R10 channel FFh unchanged", v, 16'h5AF0);
  endtask

  task automatic t_sel_busy();
    logic [15:0] v;
    int n;
    hwr(1'b1, 16'hBEEF);
    hwr(1'b0, 16'h0010);
    hwr(1'b0, 16'h4020);
    poll(n); chk("R6 store still ends on time", 16'(n), 16'd1);
    hrd(1'b0, v); chk("R6 select unchanged", v, 16'h0010);
    hwr(1'b0, 16'h4010);
    poll(n);
    hrd(1'b1, v); chk("R3 store reached channel", v, 16'hBEEF);
  endtask

  task automatic t_data_busy();
    logic [15:0] v;
    int n;
    hwr(1'b1, 16'h1111);
    hwr(1'b0, 16'h0030);
    hwr(1'b1, 16'h2222);
    poll(n);
    hrd(1'b1, v); chk("R7 data kept", v, 16'h1111);
    hwr(1'b1, 16'h0000);
    hwr(1'b0, 16'h4030);
    poll(n);
    hrd(1'b1, v); chk("R7 stored value", v, 16'h1111);
  endtask

  task automatic t_busy_bit();
    logic [15:0] v;
    int n;
    hwr(1'b1, 16'h7777);
    hwr(1'b0, 16'h8040);
    poll(n); chk("R8 busy timing unaffected", 16'(n), 16'd2);
    hrd(1'b0, v); chk("R8 busy reads 0 after access", v, 16'h0040);
    hwr(1'b0, 16'hFF41);
    hrd(1'b0, v); chk("R2 unused bits read 0", v & 16'h3FFF, 16'h0041);
    poll(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_roundtrip(8'h00, 16'hA5A5);
    t_roundtrip(8'hFF, 16'h5AF0);
    t_roundtrip(8'h5A, 16'h1234);
    t_channels();
    t_sel_busy();
    t_data_busy();
    t_busy_bit();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule